// File: doc/BRIEF.md
# Interval Prescaler with Buzzer Taps

This block turns a slow count clock into a periodic timekeeping event for real-time-clock software. It counts ticks of one of two clock-enable inputs: a 32.768 kHz subsystem tick, or a tick of the same nominal rate derived from the main clock. Each completed interval raises a one-cycle interrupt pulse and sets a sticky request flag, which software clears. With 32.768 kHz ticks, the normal interval of 16384 ticks lasts half a second. The fast interval of 128 ticks lasts about 3.9 ms and lets software test clock-keeping code quickly.

The same 14-bit binary count chain drives a buzzer pin. The pin can carry a 2 kHz square wave or a 4 kHz square wave. It can also carry a train of one-cycle pulses at the tick rate, which is about 32 kHz. The block is clocked by the system clock, and every tick input is a one-cycle enable in that domain. Oscillators and pad drivers lie outside the block.

Top module: `rtc_prescaler`

## Requirements
- R1: While reset is asserted and in the cycle after it, `irq`, `req_flag` and `buz_out` are low.
- R2: With `fast_mode` settled at 0, `irq` pulses high for exactly one cycle after every 16384 selected ticks. The count starts from the last reset, clear or source change.
- R3: With `fast_mode` at 1, `irq` pulses for one cycle after every 128 selected ticks.
- R4: A change of `fast_mode` takes effect only at the next rollover of the full 16384-tick count, or at once when the count is restarted by `clr` or by a source change. The rollover interval itself still uses the old mode.
- R5: `src_sel`=0 counts `sub_tick` and `src_sel`=1 counts `main_tick`. The unselected tick input has no effect.
- R6: A change of `src_sel` restarts the count at zero. It produces no `irq`, and the tick seen in that cycle is not counted.
- R7: `clr` held high for a cycle restarts the count at zero. It produces no `irq`, and the tick seen in that cycle is not counted.
- R8: `req_flag` becomes 1 in the same cycle as an `irq` pulse. It stays 1 until a cycle with `req_clr` high. If a new pulse arrives in that same cycle, the flag is set.
- R9: With `buz_en`=1 and `buz_sel`=2'b00, `buz_out` is count bit 3. This is a square wave with a period of 16 selected ticks (2 kHz).
- R10: With `buz_en`=1 and `buz_sel`=2'b01, `buz_out` is count bit 2. This is a square wave with a period of 8 selected ticks (4 kHz).
- R11: With `buz_en`=1 and `buz_sel`=2'b10, `buz_out` is high for exactly the cycle after each counted selected tick.
- R12: `buz_out` is low whenever `buz_en`=0 or `buz_sel`=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | Subsystem count enable, 32.768 kHz nominal |
| main_tick | input | 1 | Main-clock-derived count enable, same nominal rate |
| src_sel | input | 1 | Count source: 0 subsystem, 1 main |
| fast_mode | input | 1 | 1 selects the 128-tick interval |
| clr | input | 1 | Restarts the count at zero |
| req_clr | input | 1 | Clears the sticky request flag |
| buz_en | input | 1 | Enables the buzzer pin |
| buz_sel | input | 2 | Buzzer tap: 00 2 kHz, 01 4 kHz, 10 tick pulses, 11 off |
| irq | output | 1 | One-cycle interval interrupt |
| req_flag | output | 1 | Sticky interval request |
| buz_out | output | 1 | Buzzer output |

## Verification
The bench counts selected ticks at the ports and measures the length of every interval against a queue of expected lengths. If a design applied a mode change at once, the 16384-tick interval after the switch would come out as 128 ticks. If a design restarted without masking, clearing or switching source, it would produce a stray pulse or a long interval. Either fault shows up as a wrong length or an unexpected pulse. The unselected tick line carries the complement of the selected one, so a source mux wired backwards miscounts. The buzzer windows count high cycles and rising edges, which exposes a wrong tap bit or a pin that is not gated.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CW       = 14,
  parameter int FAST_W   = 7,
  parameter int TAP_SLOW = 3,
  parameter int TAP_MID  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       main_tick,
  input  logic       src_sel,
  input  logic       fast_mode,
  input  logic       clr,
  input  logic       req_clr,
  input  logic       buz_en,
  input  logic [1:0] buz_sel,
  output logic       irq,
  output logic       req_flag,
  output logic       buz_out
);

  logic [CW-1:0] cnt;
  logic sel_q, mode_q, pulse_q, irq_q, flag_q;

  wire tick    = src_sel ? main_tick : sub_tick;
  wire restart = clr | (src_sel != sel_q);
  wire rollover = tick & (&cnt);
  wire fast_hit = tick & (&cnt[FAST_W-1:0]);
  wire hit     = ~restart & (mode_q ? fast_hit : rollover);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      mode_q  <= 1'b0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      sel_q   <= src_sel;
      pulse_q <= tick & ~restart;
      irq_q   <= hit;
      if (restart)   cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (restart | rollover) mode_q <= fast_mode;
      if (hit)          flag_q <= 1'b1;
      else if (req_clr) flag_q <= 1'b0;
    end
  end

  logic tap;
  always_comb begin
    case (buz_sel)
      2'b00:   tap = cnt[TAP_SLOW];
      2'b01:   tap = cnt[TAP_MID];
      2'b10:   tap = pulse_q;
      default: tap = 1'b0;
    endcase
  end

  assign irq      = irq_q;
  assign req_flag = flag_q;
  assign buz_out  = buz_en & tap;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R2
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq |-> req_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (req_flag && !req_clr) |=> req_flag); // R8
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!irq && cnt == '0)); // R7
  AST_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (src_sel != sel_q) |=> (!irq && cnt == '0)); // R6
  AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cnt[FAST_W-1:0] == '0)); // R3

endmodule

// File: tb/rtc_prescaler_bench.sv
module rtc_prescaler_bench;
  logic clk = 0, rst_n = 0;
  logic sub_tick = 0, main_tick = 0, src_sel = 0, fast_mode = 0, clr = 0, req_clr = 0, buz_en = 0;
  logic [1:0] buz_sel = 2'b11;
  logic irq, req_flag, buz_out;

  rtc_prescaler u_rtc_prescaler (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int exp_q[$];
  int tcnt = 0;
  logic prev_src = 0;
  int pattern = 0;
  int phase = 0;

  // tick generator: selected line follows pattern, unselected gets the complement (R5)
  always @(negedge clk) begin
    logic g;
    phase = phase + 1;
    case (pattern)
      0: g = 1'b1;
      1: g = (phase % 3) == 0;
      2: g = phase[0];
      default: g = 1'b0;
    endcase
    sub_tick  <= src_sel ? ~g : g;
    main_tick <= src_sel ? g : ~g;
  end

  // independent tick counter at the ports
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      tcnt = 0; prev_src = 0;
    end else begin
      if (clr || src_sel != prev_src) tcnt = 0;
      else if (src_sel ? main_tick : sub_tick) tcnt = tcnt + 1;
      prev_src = src_sel;
    end
    if (cyc > 190000) begin
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      fails++; tests++;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: pop expected interval lengths
  always @(negedge clk) begin
    if (rst_n && irq) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R6/R7: unexpected irq after %0d ticks, expected none", tcnt);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (tcnt != e) begin
          fails++;
          $display("FAIL R2/R3/R4/R5: interval %0d ticks, expected %0d", tcnt, e);
        end
      end
      tcnt = 0;
    end
  end

  task automatic expect_irq(int n);
    exp_q.push_back(n);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic buz_window(string req, int exp_hi, int exp_rise);
    int hi = 0, rise = 0;
    logic last;
    @(negedge clk);
    last = buz_out;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (buz_out) hi++;
      if (buz_out && !last) rise++;
      last = buz_out;
    end
    check({req, " high cycles"}, hi, exp_hi);
    check({req, " rising edges"}, rise, exp_rise);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 req_flag", req_flag, 0);
    check("R1 buz_out", buz_out, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after release", irq, 0);
    check("R1 flag after release", req_flag, 0);

    // R2 normal interval
    expect_irq(16384);
    drain();
    check("R8 flag set", req_flag, 1);
    repeat (5) @(negedge clk);
    check("R8 flag sticky", req_flag, 1);
    req_clr = 1; @(negedge clk); req_clr = 0;
    check("R8 flag cleared", req_flag, 0);

    // R4 mode switch waits for rollover
    fast_mode = 1;
    expect_irq(16384);
    expect_irq(128); expect_irq(128); expect_irq(128);
    drain();

    // R3 with gapped ticks
    pattern = 1;
    expect_irq(128);
    drain();

    // R5 and R6: switch source mid-interval
    pattern = 0;
    repeat (60) @(negedge clk);
    src_sel = 1;
    expect_irq(128); expect_irq(128);
    drain();

    // R7 clear mid-interval
    repeat (50) @(negedge clk);
    clr = 1; @(negedge clk); clr = 0;
    expect_irq(128);
    drain();

    // R4 clear applies mode at once
    fast_mode = 0;
    repeat (20) @(negedge clk);
    clr = 1; @(negedge clk); clr = 0;
    expect_irq(16384);
    drain();

    // buzzer taps
    buz_en = 1;
    buz_sel = 2'b00; buz_window("R9", 32, 4);
    buz_sel = 2'b01; buz_window("R10", 32, 8);
    pattern = 2;
    buz_sel = 2'b10; buz_window("R11", 32, 32);
    buz_sel = 2'b11; buz_window("R12 sel 11", 0, 0);
    buz_sel = 2'b00; buz_en = 0; buz_window("R12 disabled", 0, 0);

    check("queue empty at end", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule